// File: doc/BRIEF.md
# CAN Mailbox Acceptance Filter

This block decides which of eight receive mailboxes take a received CAN frame. Each mailbox has an identifier register and an acceptance mask register. Both are reached through a small write/read register port. When an already-parsed 29-bit identifier arrives with a valid strobe, every enabled mailbox compares it with its own programmed identifier. Only the bit positions its mask selects take part in that comparison.

The mask register carries a mode bit. In base mode only the 11-bit standard identifier field is compared. In full mode the 18 extended bits are compared as well. One clock after the strobe the block presents three results: a per-mailbox match vector, a flag saying that some mailbox matched, and the index of the lowest-numbered matching mailbox.

Register writes are refused in two cases: while a global write-lock input is high, and when the addressed mailbox is enabled. This keeps the filter from ever comparing against a half-changed setting.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every mask and identifier register reads 0x00000000, and match_valid, match_vec, match_hit and match_idx are all 0.
- R2: The mask register of mailbox x is at address 0x204 + 0x20*x and holds bits 29:0; bits 31:30 read zero. The identifier register of mailbox x is at address 0x208 + 0x20*x and holds bits 28:0; bits 31:29 read zero. Any other address reads zero and is not written by a write.
- R3: While wp_en is 1, a write to any identifier or mask register leaves it unchanged.
- R4: A write to the identifier or mask register of a mailbox whose mb_en bit is 1 leaves that register unchanged.
- R5: With mask bit 29 at 0, a mailbox matches when rx_id[28:18] equals identifier bits 28:18 on every position where mask bits 28:18 are 1. rx_id[17:0] is then ignored.
- R6: With mask bit 29 at 1, a mailbox matches when rx_id[28:0] equals identifier bits 28:0 on every position where mask bits 28:0 are 1.
- R7: A mailbox whose mb_en bit was 0 at the strobe reports no match.
- R8: match_valid is 1 exactly in the cycle after a cycle with rx_valid high. match_vec, match_hit and match_idx change only in that cycle and hold their values otherwise.
- R9: match_hit is 1 when at least one match_vec bit is 1. match_idx is the lowest index among the set match_vec bits, and 0 when no bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_en | input | 1 | Global write lock for all registers |
| mb_en | input | 8 | Per-mailbox enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| rx_valid | input | 1 | Received identifier strobe |
| rx_id | input | 29 | Received identifier: base field in [28:18], extended field in [17:0] |
| match_valid | output | 1 | Result strobe, one clock after rx_valid |
| match_vec | output | 8 | Per-mailbox accept bits |
| match_hit | output | 1 | At least one mailbox accepted |
| match_idx | output | 3 | Lowest accepting mailbox |

## Verification
The assertions check several properties on every cycle. The result strobe must follow the input strobe by exactly one cycle, and the results must hold between strobes. A mailbox that was disabled at the strobe must never report a match. The hit flag and winner index must agree with the vector. Whether each accept bit is right depends on the programmed identifier, mask and mode, and so does the effect of a locked or refused write. Only the bench's scenarios can show these. It programs registers directly and at random, then compares reads and match results against its own model, across both modes, overlapping matches and writes made under lock or while a mailbox is enabled.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
    localparam int ID_W      = 29;
    localparam int BASE_W    = 11;
    localparam int EXT_W     = 18;
    localparam int MASK_W    = ID_W + 1;
    localparam int MODE_BIT  = 29;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int MASK_BASE = 'h204;
    localparam int ID_BASE   = 'h208;
    localparam int MB_STRIDE = 'h20;
endpackage

// File: rtl/cfl_regbank.sv
module cfl_regbank
    import cfl_pkg::*;
#(
    parameter int NUM_MB = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wp_en,
    input  logic [NUM_MB-1:0]                  mb_en,
    input  logic                               reg_we,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [DATA_W-1:0]                  reg_wdata,
    output logic [DATA_W-1:0]                  reg_rdata,
    output logic [NUM_MB-1:0][MASK_W-1:0]      mask_o,
    output logic [NUM_MB-1:0][ID_W-1:0]        id_o
);
    typedef struct packed {
        logic [NUM_MB-1:0][MASK_W-1:0] mask;
        logic [NUM_MB-1:0][ID_W-1:0]   id;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d    = bank_q;
        reg_rdata = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (reg_addr == ADDR_W'(MASK_BASE + i * MB_STRIDE)) begin
                reg_rdata = DATA_W'(bank_q.mask[i]);
                if (reg_we && !wp_en && !mb_en[i])
                    bank_d.mask[i] = reg_wdata[MASK_W-1:0];
            end
            if (reg_addr == ADDR_W'(ID_BASE + i * MB_STRIDE)) begin
                reg_rdata = DATA_W'(bank_q.id[i]);
                if (reg_we && !wp_en && !mb_en[i])
                    bank_d.id[i] = reg_wdata[ID_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign mask_o = bank_q.mask;
    assign id_o   = bank_q.id;
endmodule

// File: rtl/cfl_match.sv
module cfl_match
    import cfl_pkg::*;
#(
    parameter int NUM_MB = 8
) (
    input  logic [ID_W-1:0]               rx_id,
    input  logic [NUM_MB-1:0]             mb_en,
    input  logic [NUM_MB-1:0][MASK_W-1:0] mask_i,
    input  logic [NUM_MB-1:0][ID_W-1:0]   id_i,
    output logic [NUM_MB-1:0]             hit_o
);
    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        logic [ID_W-1:0] care;
        always_comb begin
            care = {mask_i[g][ID_W-1:EXT_W],
                    mask_i[g][MODE_BIT] ? mask_i[g][EXT_W-1:0] : {EXT_W{1'b0}}};
            hit_o[g] = mb_en[g] && (((rx_id ^ id_i[g]) & care) == '0);
        end
    end
endmodule

// File: rtl/cfl_prio.sv
module cfl_prio #(
    parameter int NUM_MB = 8,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic [NUM_MB-1:0] req,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_MB - 1; i >= 0; i--)
            if (req[i]) idx = IDX_W'(i);
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import cfl_pkg::*;
#(
    parameter int NUM_MB = 8,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wp_en,
    input  logic [NUM_MB-1:0]   mb_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                rx_valid,
    input  logic [ID_W-1:0]     rx_id,
    output logic                match_valid,
    output logic [NUM_MB-1:0]   match_vec,
    output logic                match_hit,
    output logic [IDX_W-1:0]    match_idx
);
    logic [NUM_MB-1:0][MASK_W-1:0] mask_w;
    logic [NUM_MB-1:0][ID_W-1:0]   id_w;
    logic [NUM_MB-1:0]             hit_w;
    logic                          any_w;
    logic [IDX_W-1:0]              idx_w;

    cfl_regbank #(.NUM_MB(NUM_MB)) u_bank (
        .clk(clk), .rst_n(rst_n), .wp_en(wp_en), .mb_en(mb_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mask_o(mask_w), .id_o(id_w)
    );

    cfl_match #(.NUM_MB(NUM_MB)) u_match (
        .rx_id(rx_id), .mb_en(mb_en), .mask_i(mask_w), .id_i(id_w),
        .hit_o(hit_w)
    );

    cfl_prio #(.NUM_MB(NUM_MB)) u_prio (
        .req(hit_w), .any(any_w), .idx(idx_w)
    );

    typedef struct packed {
        logic              vld;
        logic [NUM_MB-1:0] vec;
        logic              hit;
        logic [IDX_W-1:0]  idx;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d     = res_q;
        res_d.vld = rx_valid;
        if (rx_valid) begin
            res_d.vec = hit_w;
            res_d.hit = any_w;
            res_d.idx = idx_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign match_valid = res_q.vld;
    assign match_vec   = res_q.vec;
    assign match_hit   = res_q.hit;
    assign match_idx   = res_q.idx;
endmodule

// File: rtl/cfl_checker.sv
module cfl_checker #(
    parameter int NUM_MB = 8,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [NUM_MB-1:0] mb_en,
    input logic              match_valid,
    input logic [NUM_MB-1:0] match_vec,
    input logic              match_hit,
    input logic [IDX_W-1:0]  match_idx
);
    a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> match_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !match_valid);

    a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> ($stable(match_vec) && $stable(match_hit) && $stable(match_idx)));

    a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> ((match_vec & ~$past(mb_en)) == '0));

    a_r9_hit_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> (match_hit == (match_vec != '0)));

    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (match_valid && match_hit) |->
            (match_vec[match_idx] &&
             ((match_vec & ((NUM_MB'(1) << match_idx) - NUM_MB'(1))) == '0)));

    a_r9_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
        (match_valid && !match_hit) |-> (match_idx == '0));
endmodule

bind can_accept_filter cfl_checker #(.NUM_MB(NUM_MB)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .mb_en(mb_en),
    .match_valid(match_valid), .match_vec(match_vec),
    .match_hit(match_hit), .match_idx(match_idx)
);

// File: tb/tb_can_accept_filter.sv
`timescale 1ns/1ps
module tb_can_accept_filter;
    localparam int N = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wp_en = 0;
    logic [N-1:0] mb_en = '0;
    logic        reg_we = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 0;
    logic [28:0] rx_id = '0;
    logic        match_valid;
    logic [N-1:0] match_vec;
    logic        match_hit;
    logic [2:0]  match_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [29:0] m_mask [N];
    logic [28:0] m_id   [N];

    always #5 clk = ~clk;

    can_accept_filter dut (
        .clk(clk), .rst_n(rst_n), .wp_en(wp_en), .mb_en(mb_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_id(rx_id),
        .match_valid(match_valid), .match_vec(match_vec),
        .match_hit(match_hit), .match_idx(match_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        for (int i = 0; i < N; i++) begin
            if (a == 12'(12'h204 + i * 12'h20)) return {2'b0, m_mask[i]};
            if (a == 12'(12'h208 + i * 12'h20)) return {3'b0, m_id[i]};
        end
        return 32'h0;
    endfunction

    function automatic logic [N-1:0] model_match(input logic [28:0] rid, input logic [N-1:0] en);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            logic [28:0] care;
            care = {m_mask[i][28:18], m_mask[i][29] ? m_mask[i][17:0] : 18'h0};
            v[i] = en[i] && (((rid ^ m_id[i]) & care) == 29'h0);
        end
        return v;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        for (int i = 0; i < N; i++) begin
            if (!wp_en && !mb_en[i]) begin
                if (a == 12'(12'h204 + i * 12'h20)) m_mask[i] = d[29:0];
                if (a == 12'(12'h208 + i * 12'h20)) m_id[i] = d[28:0];
            end
        end
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a);
        reg_addr = a;
        #1;
        check(req, reg_rdata, model_read(a));
    endtask

    task automatic rx(input string req, input logic [28:0] rid);
        logic [N-1:0] ev;
        logic [2:0] ei;
        @(negedge clk);
        rx_valid = 1; rx_id = rid;
        ev = model_match(rid, mb_en);
        ei = 0;
        for (int i = N - 1; i >= 0; i--) if (ev[i]) ei = 3'(i);
        @(negedge clk);
        rx_valid = 0;
        check({req, " R8 valid"}, 32'(match_valid), 32'd1);
        check({req, " vec"}, 32'(match_vec), 32'(ev));
        check("R9 hit", 32'(match_hit), 32'(ev != 0));
        check("R9 idx", 32'(match_idx), 32'(ei));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] save_vec;
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin m_mask[i] = '0; m_id[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 match_valid", 32'(match_valid), 0);
        check("R1 match_vec", 32'(match_vec), 0);
        check("R1 hit/idx", {match_hit, match_idx}, 0);
        rd_check("R1 mask0", 12'h204);
        rd_check("R1 id7", 12'h2E8);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", 32'(match_valid), 0);

        // R2 map and reserved bits
        wr(12'h204, 32'hFFFF_FFFF);
        rd_check("R2 mask reserved bits", 12'h204);
        check("R2 mask value", reg_rdata, 32'h3FFF_FFFF);
        wr(12'h2E8, 32'hFFFF_FFFF);
        rd_check("R2 id reserved bits", 12'h2E8);
        check("R2 id value", reg_rdata, 32'h1FFF_FFFF);
        wr(12'h200, 32'h1234_5678);
        rd_check("R2 unmapped", 12'h200);
        check("R2 unmapped zero", reg_rdata, 0);

        // R3 write lock
        wp_en = 1;
        wr(12'h204, 32'h0);
        wp_en = 0;
        rd_check("R3 locked mask", 12'h204);
        check("R3 unchanged", reg_rdata, 32'h3FFF_FFFF);

        // R4 enabled mailbox refuses writes
        mb_en = 8'b0000_0100;
        wr(12'h244, 32'h2000_0001);
        wr(12'h248, 32'h0000_0005);
        rd_check("R4 mask2", 12'h244);
        rd_check("R4 id2", 12'h248);
        check("R4 id2 zero", reg_rdata, 0);
        mb_en = '0;

        // R5 base mode ignores extended bits
        wr(12'h204, {2'b0, 1'b0, 11'h7FF, 18'h3FFFF});
        wr(12'h208, {3'b0, 11'h123, 18'h00000});
        mb_en = 8'b0000_0001;
        rx("R5 ext differs", {11'h123, 18'h2AAAA});
        rx("R5 base differs", {11'h124, 18'h00000});
        // R6 full mode compares extended bits
        mb_en = '0;
        wr(12'h204, {2'b0, 1'b1, 11'h7FF, 18'h3FFFF});
        mb_en = 8'b0000_0001;
        rx("R6 ext differs", {11'h123, 18'h2AAAA});
        rx("R6 exact", {11'h123, 18'h00000});
        // R7 disabled, R9 multiple matches
        mb_en = '0;
        wr(12'h2A4, 32'h0);
        wr(12'h2C4, 32'h0);
        mb_en = 8'b0010_1000;
        rx("R7 only enabled", 29'h0ABCDEF);
        mb_en = 8'b0110_1000;
        rx("R9 lowest", 29'h1555_5555);
        mb_en = '0;
        rx("R7 none enabled", 29'h0);
        // R8 hold between strobes
        save_vec = match_vec;
        @(negedge clk);
        check("R8 no strobe", 32'(match_valid), 0);
        check("R8 held vec", 32'(match_vec), 32'(save_vec));

        // random mix
        for (int it = 0; it < 400; it++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 3) begin
                int mb;
                logic [11:0] a;
                mb = $urandom_range(0, N - 1);
                a = 12'(($urandom_range(0, 1) ? 12'h208 : 12'h204) + mb * 12'h20);
                wp_en = ($urandom_range(0, 5) == 0);
                wr(a, $urandom());
                wp_en = 0;
                rd_check(k == 0 ? "R3 random write" : "R4 random write", a);
            end else begin
                logic [28:0] rid;
                int mb;
                mb = $urandom_range(0, N - 1);
                rid = m_id[mb];
                if ($urandom_range(0, 1)) rid = rid ^ (29'($urandom()) & ~m_mask[mb][28:0]);
                else rid = 29'($urandom());
                mb_en = N'($urandom());
                rx(m_mask[mb][29] ? "R6 random" : "R5 random", rid);
                if ($urandom_range(0, 3) == 0) mb_en = '0;
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule